// File: doc/BRIEF.md
# Speculative Retirement Undo Log

This block keeps the undo history for instructions that retire speculatively past a store whose write has not yet been performed. Every instruction that retires while an older store is still outstanding gets an undo record at the tail of a circular log. A register-writing instruction records its destination physical register, the rename mapping it displaced, and the old register value. A store records its address and the cache data it overwrote. A store that is still outstanding when it retires is itself logged and marked pending. Loads only retire once they have completed, so a pending store is the only kind of entry that can still be unperformed.

When the oldest pending store performs, the block releases it together with every record behind it, up to but not including the next pending store, all in one cycle. When a coherence event hits a speculatively touched block, the pipeline requests a rollback and names a sequence tag. The block then walks back from the tail and presents up to four undo records per cycle on a restore port, youngest first, down to and including the record with that tag. The register file, rename table and cache apply the restores outside the block. While the walk runs, a stall output holds off coherence processing. Once the walk ends, speculative retirement stays blocked until all remaining pending stores have performed.

The log depth and the pending-store tracker depth must be powers of two.

Top module: `spec_history_queue`

## Requirements
- R1: After reset, retireStall, cohStall and all restoreValid lanes are 0.
- R2: A retiring instruction is logged only if a pending store is already held in the log, or if it is itself a store with retirePending=1. Any other retirement leaves no record, so a later rollback never restores it.
- R3: A rollback restores each record with the fields it was logged with. For a register entry, restoreIsStore=0, restoreLoc is the destination physical register, restoreOldMap is the prior mapping and restoreOldVal is the prior value. For a store entry, restoreIsStore=1, restoreLoc is the address and restoreOldVal is the old cache data.
- R4: A storeDone pulse releases the oldest pending store and every record up to, but not including, the next pending store. If no other pending store is held, it releases all records. Released records are never restored.
- R5: A rollback restores every held record whose tag is the same age as rbTag or younger, including the one equal to rbTag. Records leave youngest first, lane 0 holding the youngest record of a cycle.
- R6: A rollback restores at most 4 records per cycle, in contiguous lanes starting at lane 0. A walk of N records takes floor(N/4)+1 cycles, and the last cycle carries N mod 4 records.
- R7: cohStall rises on the clock edge that accepts rbReq and stays high exactly for the cycles of the walk. retireStall is high during the walk.
- R8: After a walk ends, retireStall stays high and retirements are ignored while any pending store is still held. retireStall falls one cycle after the last pending store is released.
- R9: retireStall is high whenever the log holds DEPTH records. The log never holds more than DEPTH records.
- R10: Tag age is compared modulo 2^TAGW, so a rollback target taken just before the tag wraps also undoes records tagged after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | An instruction is retiring this cycle |
| retireIsStore | input | 1 | The retiring instruction is a store |
| retirePending | input | 1 | The retiring store has not yet performed |
| retireTag | input | TAGW | Sequence tag of the retiring instruction |
| retireLoc | input | ADDRW | Destination physical register (zero-extended) or store address |
| retireOldMap | input | PREGW | Rename mapping displaced by the instruction |
| retireOldVal | input | DATAW | Old register value or old cache data |
| retireStall | output | 1 | Retirement must wait; a retirement offered while high is ignored |
| storeDone | input | 1 | The oldest pending store has performed (ignored during a walk) |
| rbReq | input | 1 | Rollback request (ignored during a walk) |
| rbTag | input | TAGW | Oldest tag to be undone |
| cohStall | output | 1 | Rollback walk in progress; hold off coherence messages |
| restoreValid | output | 4 | Per-lane restore strobe |
| restoreIsStore | output | 4 | Per-lane store flag |
| restoreTag | output | 4*TAGW | Per-lane record tag |
| restoreLoc | output | 4*ADDRW | Per-lane register number or address |
| restoreOldMap | output | 4*PREGW | Per-lane prior rename mapping |
| restoreOldVal | output | 4*DATAW | Per-lane prior value or data |

## Verification
The bench targets the boundaries of the free and undo ranges. A release that stopped on the wrong side of the next pending store, or that kept records when no pending store followed, would leak released records into a later rollback or lose live ones. Walks of 3, 5 and 9 records check the lane count per cycle and the trailing empty cycle, which an off-by-one in the stop test would shorten or extend. The bench also covers a target just before the tag wrap, which an unsigned age compare would get wrong. It covers a retirement offered during the post-rollback drain, which a design that dropped the drain phase would log.

// File: rtl/shq_pkg.sv
package shq_pkg;

  localparam int SHQ_LANES = 4;
  localparam int LANE_CW = $clog2(SHQ_LANES + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROLL,
    ST_DRAIN
  } shqState_t;

  typedef struct packed {
    logic               push;
    logic               pushPend;
    logic               popHead;
    logic [LANE_CW-1:0] undoCnt;
    logic [LANE_CW-1:0] undoPend;
  } shqStrobe_t;

endpackage

// File: rtl/shq_ctrl.sv
module shq_ctrl
  import shq_pkg::*;
#(
  parameter int TAGW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 retireValid,
  input  logic                 retireIsStore,
  input  logic                 retirePending,
  input  logic                 storeDone,
  input  logic                 rbReq,
  input  logic [TAGW-1:0]      rbTag,
  input  logic                 full,
  input  logic                 pendFull,
  input  logic                 pendAny,
  input  logic [SHQ_LANES-1:0] laneHit,
  input  logic [SHQ_LANES-1:0] lanePend,
  output shqStrobe_t           st,
  output logic [TAGW-1:0]      target,
  output logic                 retireStall,
  output logic                 rolling
);

  shqState_t state, stateN;
  logic accept, pendStore;
  logic [LANE_CW-1:0] undoC, undoP;

  assign rolling     = (state == ST_ROLL);
  assign retireStall = (state != ST_IDLE) | full | pendFull;
  assign accept      = retireValid & ~retireStall;
  assign pendStore   = retireIsStore & retirePending;

  always_comb begin
    undoC = '0;
    undoP = '0;
    if (rolling) begin
      for (int k = 0; k < SHQ_LANES; k++) begin
        undoC = undoC + LANE_CW'(laneHit[k]);
        undoP = undoP + LANE_CW'(laneHit[k] & lanePend[k]);
      end
    end
  end

  always_comb begin
    st.push     = accept & (pendAny | pendStore);
    st.pushPend = accept & pendStore;
    st.popHead  = storeDone & pendAny & ~rolling;
    st.undoCnt  = undoC;
    st.undoPend = undoP;
  end

  always_comb begin
    stateN = state;
    case (state)
      ST_IDLE:  if (rbReq) stateN = ST_ROLL;
      ST_ROLL:  if (undoC != LANE_CW'(SHQ_LANES)) stateN = ST_DRAIN;
      ST_DRAIN: begin
        if (rbReq) stateN = ST_ROLL;
        else if (!pendAny) stateN = ST_IDLE;
      end
      default:  stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      target <= '0;
    end else begin
      state <= stateN;
      if (rbReq && !rolling) target <= rbTag;
    end
  end

endmodule

// File: rtl/shq_data.sv
module shq_data
  import shq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int PEND  = 16,
  parameter int TAGW  = 8,
  parameter int ADDRW = 32,
  parameter int PREGW = 7,
  parameter int DATAW = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = IW + 1,
  localparam int PW   = $clog2(PEND),
  localparam int PCW  = PW + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  shqStrobe_t                       st,
  input  logic                             inStore,
  input  logic                             inPend,
  input  logic [TAGW-1:0]                  inTag,
  input  logic [ADDRW-1:0]                 inLoc,
  input  logic [PREGW-1:0]                 inMap,
  input  logic [DATAW-1:0]                 inVal,
  input  logic [TAGW-1:0]                  target,
  output logic                             full,
  output logic                             pendFull,
  output logic                             pendAny,
  output logic [CW-1:0]                    occ,
  output logic [SHQ_LANES-1:0]             laneHit,
  output logic [SHQ_LANES-1:0]             lanePend,
  output logic [SHQ_LANES-1:0]             laneStore,
  output logic [SHQ_LANES-1:0][TAGW-1:0]   laneTag,
  output logic [SHQ_LANES-1:0][ADDRW-1:0]  laneLoc,
  output logic [SHQ_LANES-1:0][PREGW-1:0]  laneMap,
  output logic [SHQ_LANES-1:0][DATAW-1:0]  laneVal
);

  logic             memStore [DEPTH];
  logic             memPend  [DEPTH];
  logic [TAGW-1:0]  memTag   [DEPTH];
  logic [ADDRW-1:0] memLoc   [DEPTH];
  logic [PREGW-1:0] memMap   [DEPTH];
  logic [DATAW-1:0] memVal   [DEPTH];
  logic [IW-1:0]    pendIdx  [PEND];

  logic [IW-1:0]  head, tail, headN, tailN;
  logic [CW-1:0]  occN;
  logic [PW-1:0]  pRd, pWr, pRdN, pWrN;
  logic [PCW-1:0] pCnt, pCntN;
  logic [SHQ_LANES-1:0] laneElig;

  assign full     = (occ == CW'(DEPTH));
  assign pendFull = (pCnt == PCW'(PEND));
  assign pendAny  = (pCnt != '0);

  for (genvar k = 0; k < SHQ_LANES; k++) begin : g_lane
    logic [IW-1:0]   idx;
    logic [TAGW-1:0] age;
    assign idx          = tail - IW'(k + 1);
    assign age          = memTag[idx] - target;
    assign laneElig[k]  = (CW'(k) < occ) && !age[TAGW-1];
    assign lanePend[k]  = memStore[idx] & memPend[idx];
    assign laneStore[k] = memStore[idx];
    assign laneTag[k]   = memTag[idx];
    assign laneLoc[k]   = memLoc[idx];
    assign laneMap[k]   = memMap[idx];
    assign laneVal[k]   = memVal[idx];
  end

  always_comb begin
    logic run;
    run = 1'b1;
    for (int k = 0; k < SHQ_LANES; k++) begin
      run        = run & laneElig[k];
      laneHit[k] = run;
    end
  end

  always_comb begin
    headN = head;
    tailN = tail;
    occN  = occ;
    pRdN  = pRd;
    pWrN  = pWr;
    pCntN = pCnt;
    if (st.push) begin
      tailN = tail + 1'b1;
      occN  = occ + 1'b1;
    end
    if (st.pushPend) begin
      pWrN  = pWr + 1'b1;
      pCntN = pCnt + 1'b1;
    end
    if (st.popHead) begin
      pRdN  = pRd + 1'b1;
      pCntN = pCntN - 1'b1;
      if (pCnt > PCW'(1)) begin
        headN = pendIdx[pRdN];
        occN  = occN - CW'(pendIdx[pRdN] - head);
      end else if (st.pushPend) begin
        headN = tail;
        occN  = CW'(1);
      end else begin
        headN = tailN;
        occN  = '0;
      end
    end
    if (st.undoCnt != '0) begin
      tailN = tail - IW'(st.undoCnt);
      occN  = occ - CW'(st.undoCnt);
      pWrN  = pWr - PW'(st.undoPend);
      pCntN = pCnt - PCW'(st.undoPend);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
      pRd  <= '0;
      pWr  <= '0;
      pCnt <= '0;
    end else begin
      head <= headN;
      tail <= tailN;
      occ  <= occN;
      pRd  <= pRdN;
      pWr  <= pWrN;
      pCnt <= pCntN;
    end
  end

  always_ff @(posedge clk) begin
    if (st.push) begin
      memStore[tail] <= inStore;
      memPend[tail]  <= inPend;
      memTag[tail]   <= inTag;
      memLoc[tail]   <= inLoc;
      memMap[tail]   <= inMap;
      memVal[tail]   <= inVal;
    end
    if (st.pushPend) pendIdx[pWr] <= tail;
  end

endmodule

// File: rtl/spec_history_queue.sv
module spec_history_queue
  import shq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int PEND  = 16,
  parameter int TAGW  = 8,
  parameter int ADDRW = 32,
  parameter int PREGW = 7,
  parameter int DATAW = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            retireValid,
  input  logic                            retireIsStore,
  input  logic                            retirePending,
  input  logic [TAGW-1:0]                 retireTag,
  input  logic [ADDRW-1:0]                retireLoc,
  input  logic [PREGW-1:0]                retireOldMap,
  input  logic [DATAW-1:0]                retireOldVal,
  output logic                            retireStall,
  input  logic                            storeDone,
  input  logic                            rbReq,
  input  logic [TAGW-1:0]                 rbTag,
  output logic                            cohStall,
  output logic [SHQ_LANES-1:0]            restoreValid,
  output logic [SHQ_LANES-1:0]            restoreIsStore,
  output logic [SHQ_LANES-1:0][TAGW-1:0]  restoreTag,
  output logic [SHQ_LANES-1:0][ADDRW-1:0] restoreLoc,
  output logic [SHQ_LANES-1:0][PREGW-1:0] restoreOldMap,
  output logic [SHQ_LANES-1:0][DATAW-1:0] restoreOldVal
);

  shqStrobe_t           st;
  logic [TAGW-1:0]      target;
  logic                 full, pendFull, pendAny, rolling;
  logic [CW-1:0]        occ;
  logic [SHQ_LANES-1:0] laneHit, lanePend;

  shq_ctrl #(.TAGW(TAGW)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .retireValid(retireValid), .retireIsStore(retireIsStore),
    .retirePending(retirePending), .storeDone(storeDone),
    .rbReq(rbReq), .rbTag(rbTag),
    .full(full), .pendFull(pendFull), .pendAny(pendAny),
    .laneHit(laneHit), .lanePend(lanePend),
    .st(st), .target(target), .retireStall(retireStall), .rolling(rolling)
  );

  shq_data #(
    .DEPTH(DEPTH), .PEND(PEND), .TAGW(TAGW),
    .ADDRW(ADDRW), .PREGW(PREGW), .DATAW(DATAW)
  ) data_i (
    .clk(clk), .rst_n(rst_n), .st(st),
    .inStore(retireIsStore), .inPend(retirePending), .inTag(retireTag),
    .inLoc(retireLoc), .inMap(retireOldMap), .inVal(retireOldVal),
    .target(target),
    .full(full), .pendFull(pendFull), .pendAny(pendAny), .occ(occ),
    .laneHit(laneHit), .lanePend(lanePend), .laneStore(restoreIsStore),
    .laneTag(restoreTag), .laneLoc(restoreLoc),
    .laneMap(restoreOldMap), .laneVal(restoreOldVal)
  );

  assign cohStall     = rolling;
  assign restoreValid = laneHit & {SHQ_LANES{rolling}};

endmodule

// File: rtl/shq_checker.sv
module shq_checker
  import shq_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rbReq,
  input logic                 retireStall,
  input logic                 cohStall,
  input logic [SHQ_LANES-1:0] restoreValid,
  input logic [CW-1:0]        occ
);

  // R9
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R7
  lanes_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restoreValid != '0) |-> cohStall);

  // R6
  lanes_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restoreValid & (restoreValid + SHQ_LANES'(1))) == '0);

  // R7
  walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rbReq && !cohStall) |=> cohStall);

  // R7
  walk_blocks_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cohStall |-> retireStall);

  // R8
  drain_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cohStall) |-> retireStall);

endmodule

bind spec_history_queue shq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rbReq(rbReq), .retireStall(retireStall),
  .cohStall(cohStall), .restoreValid(restoreValid), .occ(occ)
);

// File: tb/spec_history_queue_tb.sv
module spec_history_queue_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retireValid = 1'b0, retireIsStore = 1'b0, retirePending = 1'b0;
  logic [7:0] retireTag = '0;
  logic [31:0] retireLoc = '0;
  logic [6:0] retireOldMap = '0;
  logic [31:0] retireOldVal = '0;
  logic retireStall;
  logic storeDone = 1'b0, rbReq = 1'b0;
  logic [7:0] rbTag = '0;
  logic cohStall;
  logic [3:0] restoreValid, restoreIsStore;
  logic [3:0][7:0] restoreTag;
  logic [3:0][31:0] restoreLoc;
  logic [3:0][6:0] restoreOldMap;
  logic [3:0][31:0] restoreOldVal;

  int checks = 0, errors = 0;
  int gotN, cycN;
  int gotTag [64];
  int gotSt [64];
  logic [31:0] gotLoc [64];
  logic [6:0] gotMap [64];
  logic [31:0] gotVal [64];
  int cycLanes [64];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spec_history_queue #(.DEPTH(DEPTH), .PEND(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .retireValid(retireValid), .retireIsStore(retireIsStore),
    .retirePending(retirePending), .retireTag(retireTag),
    .retireLoc(retireLoc), .retireOldMap(retireOldMap),
    .retireOldVal(retireOldVal), .retireStall(retireStall),
    .storeDone(storeDone), .rbReq(rbReq), .rbTag(rbTag),
    .cohStall(cohStall), .restoreValid(restoreValid),
    .restoreIsStore(restoreIsStore), .restoreTag(restoreTag),
    .restoreLoc(restoreLoc), .restoreOldMap(restoreOldMap),
    .restoreOldVal(restoreOldVal)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic retire(input bit isSt, input bit pend, input int tag,
                        input logic [31:0] loc, input logic [6:0] map,
                        input logic [31:0] val);
    retireValid = 1'b1; retireIsStore = isSt; retirePending = pend;
    retireTag = 8'(tag); retireLoc = loc; retireOldMap = map; retireOldVal = val;
    @(negedge clk);
    retireValid = 1'b0;
  endtask

  task automatic alu(input int tag);
    retire(1'b0, 1'b0, tag, 32'(tag % 100), 7'(tag % 50), 32'hA000_0000 + 32'(tag));
  endtask

  task automatic pstore(input int tag);
    retire(1'b1, 1'b1, tag, 32'h8000 + 32'(tag), 7'd0, 32'hD000_0000 + 32'(tag));
  endtask

  task automatic doneStore();
    storeDone = 1'b1;
    @(negedge clk);
    storeDone = 1'b0;
  endtask

  task automatic rollback(input int t);
    rbReq = 1'b1; rbTag = 8'(t);
    @(negedge clk);
    rbReq = 1'b0;
    gotN = 0; cycN = 0;
    while (cohStall && cycN < 60) begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < 4; k++) begin
        if (restoreValid[k]) begin
          gotTag[gotN] = restoreTag[k]; gotSt[gotN] = restoreIsStore[k];
          gotLoc[gotN] = restoreLoc[k]; gotMap[gotN] = restoreOldMap[k];
          gotVal[gotN] = restoreOldVal[k];
          gotN++; cnt++;
        end
      end
      cycLanes[cycN] = cnt;
      cycN++;
      @(negedge clk);
    end
  endtask

  task automatic expectTags(input string req, input int n, input int e[10]);
    chk(gotN == n, req, "restored count", gotN, n);
    for (int i = 0; i < n && i < gotN; i++)
      chk(gotTag[i] == e[i], req, "restore order tag", gotTag[i], e[i]);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // R1
  task automatic testReset();
    chk(retireStall == 1'b0, "R1", "retireStall", retireStall, 0);
    chk(cohStall == 1'b0, "R1", "cohStall", cohStall, 0);
    chk(restoreValid == 4'b0, "R1", "restoreValid", restoreValid, 0);
  endtask

  // R2 R3 R5 R8
  task automatic testLogFields();
    alu(1);
    retire(1'b1, 1'b1, 2, 32'h1000, 7'd0, 32'h1111_2222);
    retire(1'b0, 1'b0, 3, 32'd5, 7'd9, 32'hCAFE_0003);
    retire(1'b1, 1'b0, 4, 32'h2000, 7'd0, 32'h3333_4444);
    rollback(1);
    expectTags("R2", 3, '{4, 3, 2, 0, 0, 0, 0, 0, 0, 0});
    chk(cycN == 1, "R5", "walk cycles", cycN, 1);
    if (gotN >= 3) begin
      chk(gotSt[0] == 1 && gotLoc[0] == 32'h2000 && gotVal[0] == 32'h3333_4444,
          "R3", "store record loc", gotLoc[0], 32'h2000);
      chk(gotSt[1] == 0 && gotLoc[1] == 32'd5 && gotMap[1] == 7'd9,
          "R3", "register record map", gotMap[1], 9);
      chk(gotVal[1] == 32'hCAFE_0003, "R3", "register record value", gotVal[1], 32'hCAFE_0003);
      chk(gotSt[2] == 1 && gotVal[2] == 32'h1111_2222, "R3", "pending store data",
          gotVal[2], 32'h1111_2222);
    end
    chk(retireStall == 1'b1, "R8", "stall right after walk", retireStall, 1);
    @(negedge clk);
    chk(retireStall == 1'b0, "R8", "stall after empty drain", retireStall, 0);
  endtask

  // R4
  task automatic testFreeRun();
    pstore(10); alu(11); alu(12); pstore(13); alu(14);
    doneStore();
    rollback(9);
    expectTags("R4", 2, '{14, 13, 0, 0, 0, 0, 0, 0, 0, 0});
    settle();
  endtask

  // R6 R7
  task automatic testWidth();
    pstore(20);
    for (int t = 21; t <= 28; t++) alu(t);
    rbReq = 1'b1; rbTag = 8'd20;
    @(negedge clk);
    rbReq = 1'b0;
    chk(cohStall == 1'b1, "R7", "cohStall after request", cohStall, 1);
    chk(retireStall == 1'b1, "R7", "retireStall during walk", retireStall, 1);
    gotN = 0; cycN = 0;
    while (cohStall && cycN < 60) begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < 4; k++)
        if (restoreValid[k]) begin gotTag[gotN] = restoreTag[k]; gotN++; cnt++; end
      cycLanes[cycN] = cnt;
      cycN++;
      @(negedge clk);
    end
    expectTags("R6", 9, '{28, 27, 26, 25, 24, 23, 22, 21, 20, 0});
    chk(cycN == 3, "R7", "cohStall cycles", cycN, 3);
    chk(cycLanes[0] == 4 && cycLanes[1] == 4, "R6", "full lanes", cycLanes[1], 4);
    chk(cycLanes[2] == 1, "R6", "last cycle lanes", cycLanes[2], 1);
    settle();
    pstore(60); alu(61); alu(62); alu(63);
    rollback(60);
    expectTags("R6", 4, '{63, 62, 61, 60, 0, 0, 0, 0, 0, 0});
    chk(cycN == 2 && cycLanes[1] == 0, "R6", "trailing empty cycle", cycN, 2);
    settle();
  endtask

  // R8
  task automatic testDrain();
    pstore(30); alu(31); pstore(32); alu(33);
    rollback(32);
    expectTags("R8", 2, '{33, 32, 0, 0, 0, 0, 0, 0, 0, 0});
    repeat (3) begin
      chk(retireStall == 1'b1, "R8", "stall while store pending", retireStall, 1);
      @(negedge clk);
    end
    alu(34);
    rollback(29);
    expectTags("R8", 2, '{31, 30, 0, 0, 0, 0, 0, 0, 0, 0});
    @(negedge clk);
    chk(retireStall == 1'b0, "R8", "stall released", retireStall, 0);
    settle();
  endtask

  // R9 R4
  task automatic testFull();
    pstore(40);
    for (int t = 41; t <= 54; t++) alu(t);
    chk(retireStall == 1'b0, "R9", "stall at DEPTH-1", retireStall, 0);
    alu(55);
    chk(retireStall == 1'b1, "R9", "stall at DEPTH", retireStall, 1);
    doneStore();
    chk(retireStall == 1'b0, "R9", "stall after release", retireStall, 0);
    rollback(39);
    expectTags("R4", 0, '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0});
    settle();
  endtask

  // R10
  task automatic testWrap();
    pstore(250);
    for (int t = 251; t <= 258; t++) alu(t % 256);
    rollback(254);
    expectTags("R10", 5, '{2, 1, 0, 255, 254, 0, 0, 0, 0, 0});
    chk(cycN == 2, "R10", "walk cycles", cycN, 2);
    doneStore();
    settle();
    chk(retireStall == 1'b0, "R10", "stall after cleanup", retireStall, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testLogFields();
    testFreeRun();
    testWidth();
    testDrain();
    testFull();
    testWrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule